// File: doc/BRIEF.md
# Dual-Access Word FIFO Channel

This block is a first-in first-out buffer of data words that can be reached along two independent paths. Software sees a small window of word-addressed registers: it can store and read back a configuration word, query empty and full flags and the fill level, push words in, pop words out and clear the whole buffer. Hardware sees a raw streaming pair: a push strobe with its data word, and a pop strobe whose data output always shows the oldest stored word ahead of the strobe.

Both paths act on the same storage. Each clock at most one word enters and at most one word leaves. When both paths push in the same cycle, the hardware word wins. When both paths pop, the hardware pop wins. A push and a pop from any mix of paths may complete together. The fill level register is only as wide as needed to count up to depth minus one, so it reads zero both when empty and when full; the flags tell the two apart.

Top module: `regfifo_channel`

## Requirements
- R1: After a synchronous reset the buffer is empty: address 1 reads 0x00000001, address 2 reads 0x00000000, address 3 reads 0, and address 0 (configuration) reads 0.
- R2: A word written to address 0 reads back unchanged from address 0. Every register read returns its data on `bus_rdata` one clock after the read strobe is sampled, and `bus_rdata` holds its value while no read is issued.
- R3: A write to address 4 appends the word; a read of address 5 returns the oldest word and removes it, so words leave in arrival order. Address 1 reads 0x00000001 when no word is stored and 0x00000000 otherwise.
- R4: Address 2 reads 0x00000001 when the buffer holds DEPTH words and 0x00000000 otherwise. Address 3 reads the stored count modulo DEPTH, so it reads 0 when full.
- R5: The hardware push path stores the value on `strm_in_data` once for every clock in which `strm_in_valid` is high.
- R6: `strm_out_data` shows the oldest stored word with no strobe; one clock of `strm_out_take` removes it and the next word appears.
- R7: A push from either path while the buffer is full is ignored and stored contents and order are preserved.
- R8: A pop from either path while empty is ignored and the level stays 0; a read of address 5 that removes nothing returns the word most recently removed through address 5 (0 after reset).
- R9: Writing exactly 0x00000001 to address 6 empties the buffer and takes precedence over any push or pop in the same cycle; any other value written there has no effect.
- R10: Writes to addresses 1, 2, 3 and 5 change no state; reads of addresses 7 to 15 return 0.
- R11: A push and a pop in the same clock (any combination of paths) both complete and leave the level unchanged; when full, the pop completes and the same-cycle push is dropped, judged against the occupancy before the clock.
- R12: A same-cycle push from both paths stores only the hardware word; a same-cycle pop from both paths removes one word through the hardware path, and the software read then returns the word most recently removed through address 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 4 | Register word address |
| bus_write | input | 1 | Register write strobe |
| bus_wdata | input | DATA_W | Register write data |
| bus_read | input | 1 | Register read strobe |
| bus_rdata | output | DATA_W | Register read data, one clock after the read |
| strm_in_valid | input | 1 | Hardware push strobe |
| strm_in_data | input | DATA_W | Hardware push data |
| strm_out_take | input | 1 | Hardware pop strobe |
| strm_out_data | output | DATA_W | Oldest stored word, shown ahead of the pop |

## Verification
The functions that collide are a push and a pop landing in the same clock from opposite paths, and a clear landing on top of a push. The bench provokes these by raising the hardware strobe in the very cycle a register read of address 5 or a register write of addresses 4 or 6 is issued, with the buffer partly filled, full and empty. Outcomes are judged against an arithmetic occupancy and order model in the bench: the level read back, the word returned on the register port and the word shown next on the hardware output.

// File: rtl/regfifo_pkg.sv
package regfifo_pkg;

    typedef enum logic [3:0] {
        REG_CFG   = 4'd0,
        REG_EMPTY = 4'd1,
        REG_FULL  = 4'd2,
        REG_LEVEL = 4'd3,
        REG_PUSH  = 4'd4,
        REG_POP   = 4'd5,
        REG_CLEAR = 4'd6
    } reg_sel_e;

    // Operation requests presented to the storage each clock
    typedef struct packed {
        logic hw_push;
        logic sw_push;
        logic hw_pop;
        logic sw_pop;
        logic clear;
    } fifo_req_t;

    localparam int unsigned CLEAR_KEY = 1;

    function automatic logic [31:0] flag_word(input logic b);
        return {31'd0, b};
    endfunction

endpackage

// File: rtl/regfifo_store.sv
module regfifo_store
    import regfifo_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int DEPTH_LOG2 = 10
) (
    input  logic                  clk,
    input  logic                  rst,
    input  fifo_req_t             req,
    input  logic [DATA_W-1:0]     hw_wdata,
    input  logic [DATA_W-1:0]     sw_wdata,
    output logic [DATA_W-1:0]     head,
    output logic [DEPTH_LOG2:0]   count,
    output logic                  sw_pop_ok
);
    localparam int DEPTH = 1 << DEPTH_LOG2;
    localparam logic [DEPTH_LOG2:0] DEPTH_CNT = (DEPTH_LOG2+1)'(DEPTH);

    logic [DATA_W-1:0]     mem [DEPTH];
    logic [DEPTH_LOG2-1:0] wr_ptr, rd_ptr;
    logic                  full, empty;
    logic                  push_any, pop_any, push_ok, pop_ok;
    logic [DATA_W-1:0]     push_data;

    assign full      = (count == DEPTH_CNT);
    assign empty     = (count == '0);
    assign push_any  = req.hw_push | req.sw_push;
    assign pop_any   = req.hw_pop | req.sw_pop;
    // hardware word wins when both paths push together
    assign push_data = req.hw_push ? hw_wdata : sw_wdata;
    assign push_ok   = push_any & ~full & ~req.clear;
    assign pop_ok    = pop_any & ~empty & ~req.clear;
    assign sw_pop_ok = pop_ok & req.sw_pop & ~req.hw_pop;
    assign head      = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst || req.clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= DEPTH_CNT);
    a_r7_full_push_blocked: assert property (@(posedge clk) disable iff (rst)
        (full && push_any && !req.clear) |=> $stable(wr_ptr));
    a_r8_empty_pop_blocked: assert property (@(posedge clk) disable iff (rst)
        (empty && pop_any && !req.clear) |=> $stable(rd_ptr));
    a_r9_clear_empties: assert property (@(posedge clk) disable iff (rst)
        req.clear |=> (count == '0));
    a_r11_balanced_level: assert property (@(posedge clk) disable iff (rst)
        (push_ok && pop_ok) |=> $stable(count));

endmodule

// File: rtl/regfifo_regs.sv
module regfifo_regs
    import regfifo_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int DEPTH_LOG2 = 10
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [3:0]            bus_addr,
    input  logic                  bus_write,
    input  logic [DATA_W-1:0]     bus_wdata,
    input  logic                  bus_read,
    input  logic [DEPTH_LOG2:0]   count,
    input  logic [DATA_W-1:0]     head,
    input  logic                  sw_pop_ok,
    output logic                  sw_push,
    output logic                  sw_pop,
    output logic                  clear,
    output logic [DATA_W-1:0]     bus_rdata
);
    localparam int DEPTH = 1 << DEPTH_LOG2;
    localparam logic [DEPTH_LOG2:0] DEPTH_CNT = (DEPTH_LOG2+1)'(DEPTH);

    logic [DATA_W-1:0] cfg_q;
    logic [DATA_W-1:0] last_pop_q;
    logic [DATA_W-1:0] rd_mux;

    assign sw_push = bus_write && (bus_addr == REG_PUSH);
    assign sw_pop  = bus_read  && (bus_addr == REG_POP);
    assign clear   = bus_write && (bus_addr == REG_CLEAR)
                     && (bus_wdata == DATA_W'(CLEAR_KEY));

    always_comb begin
        case (bus_addr)
            REG_CFG:   rd_mux = cfg_q;
            REG_EMPTY: rd_mux = DATA_W'(flag_word(count == '0));
            REG_FULL:  rd_mux = DATA_W'(flag_word(count == DEPTH_CNT));
            REG_LEVEL: rd_mux = DATA_W'(count[DEPTH_LOG2-1:0]);
            REG_POP:   rd_mux = sw_pop_ok ? head : last_pop_q;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q      <= '0;
            last_pop_q <= '0;
            bus_rdata  <= '0;
        end else begin
            if (bus_write && (bus_addr == REG_CFG)) cfg_q <= bus_wdata;
            if (sw_pop_ok) last_pop_q <= head;
            if (bus_read)  bus_rdata  <= rd_mux;
        end
    end

    a_r2_cfg_store: assert property (@(posedge clk) disable iff (rst)
        (bus_write && bus_addr == REG_CFG) |=> (cfg_q == $past(bus_wdata)));
    a_r2_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !bus_read |=> $stable(bus_rdata));
    a_r12_sw_pop_yields: assert property (@(posedge clk) disable iff (rst)
        sw_pop_ok |-> sw_pop);

endmodule

// File: rtl/regfifo_channel.sv
module regfifo_channel
    import regfifo_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int DEPTH_LOG2 = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        bus_addr,
    input  logic              bus_write,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_read,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              strm_in_valid,
    input  logic [DATA_W-1:0] strm_in_data,
    input  logic              strm_out_take,
    output logic [DATA_W-1:0] strm_out_data
);
    fifo_req_t              req;
    logic                   sw_push, sw_pop, clear, sw_pop_ok;
    logic [DEPTH_LOG2:0]    count;
    logic [DATA_W-1:0]      head;

    assign req = '{hw_push: strm_in_valid, sw_push: sw_push,
                   hw_pop:  strm_out_take, sw_pop:  sw_pop,
                   clear:   clear};
    assign strm_out_data = head;

    regfifo_regs #(.DATA_W(DATA_W), .DEPTH_LOG2(DEPTH_LOG2)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_write (bus_write),
        .bus_wdata (bus_wdata),
        .bus_read  (bus_read),
        .count     (count),
        .head      (head),
        .sw_pop_ok (sw_pop_ok),
        .sw_push   (sw_push),
        .sw_pop    (sw_pop),
        .clear     (clear),
        .bus_rdata (bus_rdata)
    );

    regfifo_store #(.DATA_W(DATA_W), .DEPTH_LOG2(DEPTH_LOG2)) u_store (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .hw_wdata  (strm_in_data),
        .sw_wdata  (bus_wdata),
        .head      (head),
        .count     (count),
        .sw_pop_ok (sw_pop_ok)
    );

endmodule

// File: tb/regfifo_channel_test.sv
`timescale 1ns/1ps
module regfifo_channel_test;
    localparam int DW = 32;
    localparam int DL = 3;
    localparam int DEPTH = 1 << DL;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    bus_addr = '0;
    logic          bus_write = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic          bus_read = 1'b0;
    logic [DW-1:0] bus_rdata;
    logic          strm_in_valid = 1'b0;
    logic [DW-1:0] strm_in_data = '0;
    logic          strm_out_take = 1'b0;
    logic [DW-1:0] strm_out_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [DW-1:0] q[$];
    logic [DW-1:0] last_sw = '0;

    always #2.5 clk = ~clk;

    regfifo_channel #(.DATA_W(DW), .DEPTH_LOG2(DL)) uut (.*);

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic mm_wr(input logic [3:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_write = 1'b1;
        @(negedge clk);
        bus_write = 1'b0;
    endtask

    task automatic mm_rd(input logic [3:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_read = 1'b1;
        @(negedge clk);
        bus_read = 1'b0;
        d = bus_rdata;
    endtask

    task automatic hw_push1(input logic [DW-1:0] d);
        @(negedge clk);
        strm_in_valid = 1'b1; strm_in_data = d;
        @(negedge clk);
        strm_in_valid = 1'b0;
    endtask

    task automatic state_chk(input string tag);
        logic [DW-1:0] v;
        mm_rd(4'd3, v); chk({tag, " level"}, v, DW'(q.size() % DEPTH));
        mm_rd(4'd1, v); chk({tag, " empty"}, v, DW'(q.size() == 0));
        mm_rd(4'd2, v); chk({tag, " full"}, v, DW'(q.size() == DEPTH));
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        state_chk("R1");
        mm_rd(4'd0, v); chk("R1 cfg", v, '0);

        // R2 configuration round trip sweep
        for (int i = 0; i < 32; i++) begin
            logic [DW-1:0] p = (32'h1 << i) ^ (32'hA5C3_0F96 * i);
            mm_wr(4'd0, p);
            mm_rd(4'd0, v); chk("R2 cfg", v, p);
        end
        mm_rd(4'd0, v);
        @(negedge clk); @(negedge clk);
        chk("R2 hold", bus_rdata, v);

        // R3/R4 software fill, level after each word
        for (int i = 1; i <= DEPTH; i++) begin
            logic [DW-1:0] w = 32'h1000_0000 + i * 32'h0101;
            mm_wr(4'd4, w); q.push_back(w);
            state_chk("R4");
        end
        // R7 pushes into full from both paths
        mm_wr(4'd4, 32'hDEAD_0001);
        hw_push1(32'hBEEF_0002);
        state_chk("R7");
        chk("R7 head", strm_out_data, q[0]);

        // R3 drain in order
        while (q.size() > 0) begin
            mm_rd(4'd5, v);
            last_sw = q.pop_front();
            chk("R3 order", v, last_sw);
        end
        state_chk("R3");
        // R8 pops on empty
        mm_rd(4'd5, v); chk("R8 last word", v, last_sw);
        @(negedge clk); strm_out_take = 1'b1; @(negedge clk); strm_out_take = 1'b0;
        state_chk("R8");

        // R5 burst hardware push, R6 show-ahead drain
        @(negedge clk);
        for (int i = 0; i < DEPTH; i++) begin
            strm_in_valid = 1'b1; strm_in_data = 32'h2000_0000 | (i * 7);
            q.push_back(strm_in_data);
            @(negedge clk);
        end
        strm_in_valid = 1'b0;
        state_chk("R5");
        while (q.size() > 0) begin
            @(negedge clk);
            chk("R6 show-ahead", strm_out_data, q[0]);
            strm_out_take = 1'b1;
            @(negedge clk);
            strm_out_take = 1'b0;
            void'(q.pop_front());
        end
        state_chk("R6");

        // R9 clear key
        for (int i = 0; i < 3; i++) begin hw_push1(32'h3000_0000 + i); q.push_back(32'h3000_0000 + i); end
        mm_wr(4'd6, 32'h0000_0002);
        state_chk("R9 wrong key");
        mm_wr(4'd6, 32'h0000_0001); q.delete();
        state_chk("R9 clear");
        // R9 clear beats same-cycle push
        @(negedge clk);
        bus_addr = 4'd6; bus_wdata = 32'h1; bus_write = 1'b1;
        strm_in_valid = 1'b1; strm_in_data = 32'h3333_3333;
        @(negedge clk);
        bus_write = 1'b0; strm_in_valid = 1'b0;
        state_chk("R9 clear vs push");

        // R10 writes to read-only addresses
        hw_push1(32'h4000_0001); q.push_back(32'h4000_0001);
        hw_push1(32'h4000_0002); q.push_back(32'h4000_0002);
        for (int a = 1; a <= 5; a++) begin
            if (a != 4) mm_wr(4'(a), 32'hFFFF_FFFF);
        end
        state_chk("R10");
        chk("R10 head", strm_out_data, q[0]);
        for (int a = 7; a < 16; a++) begin
            mm_rd(4'(a), v); chk("R10 unmapped", v, '0);
        end

        // R11 hw push with sw pop in one clock
        @(negedge clk);
        strm_in_valid = 1'b1; strm_in_data = 32'h5000_0005;
        bus_addr = 4'd5; bus_read = 1'b1;
        @(negedge clk);
        strm_in_valid = 1'b0; bus_read = 1'b0;
        last_sw = q.pop_front(); q.push_back(32'h5000_0005);
        chk("R11 sw pop", bus_rdata, last_sw);
        chk("R11 next head", strm_out_data, q[0]);
        state_chk("R11 level");
        // R11 full: hw pop with sw push, push dropped
        while (q.size() < DEPTH) begin
            hw_push1(32'h6000_0000 + q.size()); q.push_back(32'h6000_0000 + q.size());
        end
        @(negedge clk);
        strm_out_take = 1'b1; bus_addr = 4'd4; bus_wdata = 32'h6666_6666; bus_write = 1'b1;
        @(negedge clk);
        strm_out_take = 1'b0; bus_write = 1'b0;
        void'(q.pop_front());
        state_chk("R11 full");
        chk("R11 full head", strm_out_data, q[0]);

        // R12 both paths push: hw word kept
        mm_wr(4'd6, 32'h1); q.delete();
        @(negedge clk);
        strm_in_valid = 1'b1; strm_in_data = 32'h7000_00AA;
        bus_addr = 4'd4; bus_wdata = 32'h7000_00BB; bus_write = 1'b1;
        @(negedge clk);
        strm_in_valid = 1'b0; bus_write = 1'b0;
        q.push_back(32'h7000_00AA);
        state_chk("R12 dual push");
        chk("R12 stored word", strm_out_data, 32'h7000_00AA);
        hw_push1(32'h7000_00CC); q.push_back(32'h7000_00CC);
        // R12 both paths pop: hw removes, sw gets last sw word
        @(negedge clk);
        strm_out_take = 1'b1; bus_addr = 4'd5; bus_read = 1'b1;
        @(negedge clk);
        strm_out_take = 1'b0; bus_read = 1'b0;
        void'(q.pop_front());
        chk("R12 sw read", bus_rdata, last_sw);
        chk("R12 head", strm_out_data, 32'h7000_00CC);
        state_chk("R12 dual pop");

        done = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule